// File: doc/BRIEF.md
# Traffic-Class Channel Transmit Scheduler

This block sits on the transmit side of a serial link that carries several classes of traffic. Each outgoing transaction arrives with a traffic-class tag. A table that software can write maps the class to one of several virtual channels. The transaction is stored in that channel's own queue. Every channel keeps its own count of the buffer space the far receiver has free, counted in whole transactions. Each cycle a scheduler picks at most one channel that has both queued work and credit, and places its oldest entry on the single link output.

One channel may be marked as the time-critical channel. When it has work and credit it always wins. The other channels take turns in rotating order, so none of them is left waiting forever. A channel that is out of credit, or whose queue is full, holds up only itself: the other channels keep sending, and the input refuses only those classes that map to the full queue.

Top module: `tc_vc_sched`

## Requirements
- R1: After reset every traffic class maps to channel 0, every queue is empty, every channel holds INIT_CRED credits, `in_ready` is high and `out_valid` is low.
- R2: A cycle with `map_we` high sets the channel of class `map_tc` to `map_vc`. The write is dropped when `map_vc` is not below NUM_VC, and the old mapping stays.
- R3: A table write changes the channel only for transactions accepted in later cycles. Entries already queued leave on the channel they were queued in.
- R4: `in_ready` is low only when the queue of the channel that `in_tc` currently maps to holds QDEPTH entries. A transaction offered while `in_ready` is low is dropped and never appears on the output.
- R5: A channel sends only while its credit count is above zero. Each send lowers the count by one, so a channel with N credits and a longer queue sends exactly N entries and then stops.
- R6: A cycle with `cr_valid` high adds `cr_cnt` to the credit count of channel `cr_vc`. When the same channel also sends in that cycle, both changes are applied.
- R7: A transaction accepted at clock edge k can appear on the output after edge k+1 at the earliest. Each cycle with `out_valid` high carries exactly one transaction, with its channel, class and data.
- R8: When ISO_EN is set and channel ISO_VC has queued work and credit, that channel is chosen ahead of all others.
- R9: The other eligible channels are served in rotating order, starting from the channel after the last one served in rotation.
- R10: A channel that is blocked by missing credit or by a full queue does not delay the acceptance or sending of traffic on any other channel.
- R11: Within one channel, entries leave in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Transaction offered |
| in_tc | input | TC_W | Traffic class of the offered transaction |
| in_data | input | DATA_W | Transaction payload |
| in_ready | output | 1 | Queue of the mapped channel has room |
| cr_valid | input | 1 | Credit return strobe |
| cr_vc | input | VC_W | Channel receiving credits |
| cr_cnt | input | CRED_W | Number of transactions of credit returned |
| map_we | input | 1 | Mapping table write strobe |
| map_tc | input | TC_W | Class whose mapping is written |
| map_vc | input | 3 | New channel for that class |
| out_valid | output | 1 | A transaction is on the link output |
| out_vc | output | VC_W | Channel of the output transaction |
| out_tc | output | TC_W | Class of the output transaction |
| out_data | output | DATA_W | Payload of the output transaction |

## Verification
The assertions assume that the link partner never returns more credit than a channel's counter can hold, so that a count plus a return never wraps. The stimulus keeps to this rule by tracking each channel's credit in the bench and returning only small amounts. The assertions also assume that `cr_vc` names an existing channel, and every return in the stimulus does. Inputs change only between clock edges, one transaction per cycle. The stimulus creates contention between channels by holding queues behind zero credit and then releasing credits one channel per cycle, which makes the order of sends predictable.

// File: rtl/tcvc_pkg.sv
`timescale 1ns/1ps
package tcvc_pkg;
   localparam int MAX_CLASSES  = 8;
   localparam int MAX_CHANNELS = 8;
   localparam int SEL_W        = 3;

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tcvc_map.sv
`timescale 1ns/1ps
module tcvc_map #(
   parameter int NUM_TC = 8,
   parameter int NUM_VC = 4,
   parameter int TC_W   = 3,
   parameter int VC_W   = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [TC_W-1:0]           wr_tc,
   input  logic [tcvc_pkg::SEL_W-1:0] wr_vc,
   input  logic [TC_W-1:0]           rd_tc,
   output logic [VC_W-1:0]           rd_vc
);
   logic [NUM_TC-1:0][VC_W-1:0] map_q;
   logic                        wr_ok;

   assign wr_ok = wr_en && (int'(wr_vc) < NUM_VC) && (int'(wr_tc) < NUM_TC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         map_q <= '0;
      end else if (wr_ok) begin
         map_q[wr_tc] <= wr_vc[VC_W-1:0];
      end
   end

   assign rd_vc = (int'(rd_tc) < NUM_TC) ? map_q[rd_tc] : '0;

   // R2: an out-of-range channel number leaves the whole table unchanged
   a_r2_wide_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_vc) >= NUM_VC) |=> $stable(map_q));

   // R2: a looked-up channel always names an existing queue
   a_r2_lookup_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rd_vc) < NUM_VC);
endmodule

// File: rtl/tcvc_fifo.sv
`timescale 1ns/1ps
module tcvc_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int PTR_W = tcvc_pkg::idx_w(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q;
   logic [CNT_W-1:0] cnt_q;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (int'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (push) mem[wr_q] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= bump(wr_q);
         if (pop)  rd_q <= bump(rd_q);
         cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
      end
   end

   assign rdata = mem[rd_q];
   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CNT_W'(DEPTH));

   // R4: the input never writes into a full queue
   a_r4_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R11: the scheduler never takes from an empty queue
   a_r11_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/tcvc_credit.sv
`timescale 1ns/1ps
module tcvc_credit #(
   parameter int CRED_W    = 8,
   parameter int INIT_CRED = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              send,
   input  logic              ret_en,
   input  logic [CRED_W-1:0] ret_cnt,
   output logic              has_cred
);
   logic [CRED_W-1:0] cnt_q;
   logic [CRED_W-1:0] add;

   assign add = ret_en ? ret_cnt : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= CRED_W'(INIT_CRED);
      else        cnt_q <= cnt_q + add - CRED_W'(send);
   end

   assign has_cred = (cnt_q != '0);

   // R5: no send is granted against an empty counter
   a_r5_send_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
      send |-> cnt_q != '0);

   // R6: without a send or a return the count holds
   a_r6_idle_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!send && !ret_en) |=> $stable(cnt_q));

   // R6: input assumption, the partner never returns more than the counter can hold
   a_r6_return_fits: assert property (@(posedge clk) disable iff (!rst_n)
      ret_en |-> ({1'b0, cnt_q} + {1'b0, ret_cnt}) <= {1'b0, {CRED_W{1'b1}}});
endmodule

// File: rtl/tcvc_arb.sv
`timescale 1ns/1ps
module tcvc_arb #(
   parameter int N       = 4,
   parameter bit ISO_EN  = 1'b1,
   parameter int ISO_IDX = 3,
   parameter int IDX_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     elig,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] grant_idx
);
   logic [IDX_W-1:0] ptr_q;
   logic [N-1:0]     rr_grant;
   logic             iso_won;

   always_comb begin
      int  idx;
      logic hit;
      rr_grant = '0;
      hit      = 1'b0;
      idx      = 0;
      for (int i = 0; i < N; i++) begin
         idx = int'(ptr_q) + i;
         if (idx >= N) idx = idx - N;
         if (!hit && elig[idx]) begin
            hit           = 1'b1;
            rr_grant[idx] = 1'b1;
         end
      end
   end

   generate
      if (ISO_EN) begin : g_iso_first
         assign grant   = elig[ISO_IDX] ? (N'(1) << ISO_IDX) : rr_grant;
         assign iso_won = elig[ISO_IDX];
      end else begin : g_rr_only
         assign grant   = rr_grant;
         assign iso_won = 1'b0;
      end
   endgenerate

   always_comb begin
      grant_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) grant_idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (|grant && !iso_won) begin
         ptr_q <= (int'(grant_idx) == N - 1) ? '0 : grant_idx + IDX_W'(1);
      end
   end

   // R7: at most one channel per cycle
   a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R5: only channels with work and credit are granted
   a_r5_grant_is_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~elig) == '0);

   // R10: any eligible channel means something is sent
   a_r10_no_idle_with_work: assert property (@(posedge clk) disable iff (!rst_n)
      (|elig) |-> (|grant));

   generate
      if (ISO_EN) begin : g_iso_chk
         // R8: the time-critical channel wins whenever it can send
         a_r8_iso_wins: assert property (@(posedge clk) disable iff (!rst_n)
            elig[ISO_IDX] |-> grant[ISO_IDX]);
      end
   endgenerate
endmodule

// File: rtl/tc_vc_sched.sv
`timescale 1ns/1ps
module tc_vc_sched #(
   parameter int DATA_W    = 32,
   parameter int NUM_TC    = 8,
   parameter int NUM_VC    = 4,
   parameter int QDEPTH    = 4,
   parameter int CRED_W    = 8,
   parameter int INIT_CRED = 8,
   parameter bit ISO_EN    = 1'b1,
   parameter int ISO_VC    = NUM_VC - 1,
   localparam int TC_W     = tcvc_pkg::idx_w(NUM_TC),
   localparam int VC_W     = tcvc_pkg::idx_w(NUM_VC)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [TC_W-1:0]            in_tc,
   input  logic [DATA_W-1:0]          in_data,
   output logic                       in_ready,
   input  logic                       cr_valid,
   input  logic [VC_W-1:0]            cr_vc,
   input  logic [CRED_W-1:0]          cr_cnt,
   input  logic                       map_we,
   input  logic [TC_W-1:0]            map_tc,
   input  logic [tcvc_pkg::SEL_W-1:0] map_vc,
   output logic                       out_valid,
   output logic [VC_W-1:0]            out_vc,
   output logic [TC_W-1:0]            out_tc,
   output logic [DATA_W-1:0]          out_data
);
   localparam int ENT_W = TC_W + DATA_W;

   generate
      if (NUM_TC < 1 || NUM_TC > tcvc_pkg::MAX_CLASSES) begin : g_bad_tc
         $error("NUM_TC out of range");
      end
      if (NUM_VC < 1 || NUM_VC > tcvc_pkg::MAX_CHANNELS) begin : g_bad_vc
         $error("NUM_VC out of range");
      end
      if (QDEPTH < 2) begin : g_bad_depth
         $error("QDEPTH must be at least 2");
      end
      if (INIT_CRED < 0 || INIT_CRED >= (1 << CRED_W)) begin : g_bad_cred
         $error("INIT_CRED does not fit CRED_W");
      end
      if (ISO_EN && (ISO_VC < 0 || ISO_VC >= NUM_VC)) begin : g_bad_iso
         $error("ISO_VC out of range");
      end
   endgenerate

   logic [VC_W-1:0]   in_vc;
   logic [NUM_VC-1:0] q_full, q_empty, q_push, has_cred, elig, grant;
   logic [ENT_W-1:0]  q_head [NUM_VC];
   logic [VC_W-1:0]   grant_idx;
   logic [ENT_W-1:0]  sel_head;

   tcvc_map #(
      .NUM_TC (NUM_TC),
      .NUM_VC (NUM_VC),
      .TC_W   (TC_W),
      .VC_W   (VC_W)
   ) u_map (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (map_we),
      .wr_tc (map_tc),
      .wr_vc (map_vc),
      .rd_tc (in_tc),
      .rd_vc (in_vc)
   );

   assign in_ready = !q_full[in_vc];

   generate
      for (genvar v = 0; v < NUM_VC; v++) begin : g_chan
         assign q_push[v] = in_valid && in_ready && (in_vc == VC_W'(v));
         assign elig[v]   = !q_empty[v] && has_cred[v];

         tcvc_fifo #(
            .W     (ENT_W),
            .DEPTH (QDEPTH)
         ) u_queue (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[v]),
            .wdata ({in_tc, in_data}),
            .pop   (grant[v]),
            .rdata (q_head[v]),
            .empty (q_empty[v]),
            .full  (q_full[v])
         );

         tcvc_credit #(
            .CRED_W    (CRED_W),
            .INIT_CRED (INIT_CRED)
         ) u_credit (
            .clk      (clk),
            .rst_n    (rst_n),
            .send     (grant[v]),
            .ret_en   (cr_valid && (cr_vc == VC_W'(v))),
            .ret_cnt  (cr_cnt),
            .has_cred (has_cred[v])
         );
      end
   endgenerate

   tcvc_arb #(
      .N       (NUM_VC),
      .ISO_EN  (ISO_EN),
      .ISO_IDX (ISO_VC),
      .IDX_W   (VC_W)
   ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .elig      (elig),
      .grant     (grant),
      .grant_idx (grant_idx)
   );

   assign sel_head = q_head[grant_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_vc    <= '0;
         out_tc    <= '0;
         out_data  <= '0;
      end else begin
         out_valid <= |grant;
         out_vc    <= grant_idx;
         out_tc    <= sel_head[ENT_W-1:DATA_W];
         out_data  <= sel_head[DATA_W-1:0];
      end
   end

   // R7: an output transaction always names an existing channel
   a_r7_out_vc_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> int'(out_vc) < NUM_VC);

   // R4: a refused class is refused because its own queue is full
   a_r4_refusal_is_local: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> $countones(q_full) >= 1);
endmodule

// File: tb/test_tc_vc_sched.sv
`timescale 1ns/1ps
module test_tc_vc_sched;
   localparam int NTC = 8;
   localparam int NVC = 4;
   localparam int QD  = 4;
   localparam int CW  = 6;
   localparam int IC  = 2;
   localparam int DW  = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [2:0]    in_tc = '0;
   logic [DW-1:0] in_data = '0;
   logic          in_ready;
   logic          cr_valid = 1'b0;
   logic [1:0]    cr_vc = '0;
   logic [CW-1:0] cr_cnt = '0;
   logic          map_we = 1'b0;
   logic [2:0]    map_tc = '0;
   logic [2:0]    map_vc = '0;
   logic          out_valid;
   logic [1:0]    out_vc;
   logic [2:0]    out_tc;
   logic [DW-1:0] out_data;

   int n_chk = 0;
   int n_err = 0;
   int log_vc [256];
   int log_tc [256];
   int log_d  [256];
   int log_n = 0;
   int cred_model [NVC];
   int dseq = 16'h100;
   bit done = 1'b0;

   tc_vc_sched #(
      .DATA_W (DW), .NUM_TC (NTC), .NUM_VC (NVC), .QDEPTH (QD),
      .CRED_W (CW), .INIT_CRED (IC), .ISO_EN (1'b1), .ISO_VC (3)
   ) i_tc_vc_sched (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_tc (in_tc), .in_data (in_data), .in_ready (in_ready),
      .cr_valid (cr_valid), .cr_vc (cr_vc), .cr_cnt (cr_cnt),
      .map_we (map_we), .map_tc (map_tc), .map_vc (map_vc),
      .out_valid (out_valid), .out_vc (out_vc), .out_tc (out_tc), .out_data (out_data)
   );

   always #10 clk = ~clk;

   always @(negedge clk) begin
      if (rst_n && out_valid && log_n < 256) begin
         log_vc[log_n] = int'(out_vc);
         log_tc[log_n] = int'(out_tc);
         log_d[log_n]  = int'(out_data);
         cred_model[out_vc] = cred_model[out_vc] - 1;
         log_n = log_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input bit v, input int tc, input int d, input bit cv, input int cvc,
                       input int cn, input bit mw, input int mt, input int mv);
      @(negedge clk);
      in_valid = v;   in_tc = tc[2:0];   in_data = d[DW-1:0];
      cr_valid = cv;  cr_vc = cvc[1:0];  cr_cnt = cn[CW-1:0];
      map_we = mw;    map_tc = mt[2:0];  map_vc = mv[2:0];
      if (cv) cred_model[cvc] = cred_model[cvc] + cn;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic push(input int tc, input int d);
      step(1, tc, d, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic ret(input int vc, input int n);
      step(0, 0, 0, 1, vc, n, 0, 0, 0);
   endtask

   task automatic mapw(input int tc, input int vc);
      step(0, 0, 0, 0, 0, 0, 1, tc, vc);
   endtask

   task automatic entry(input int idx, input int vc, input int tc, input int d, input string req);
      chk(log_vc[idx] == vc, req, "channel", log_vc[idx], vc);
      chk(log_tc[idx] == tc, req, "class", log_tc[idx], tc);
      chk(log_d[idx] == d, req, "data", log_d[idx], d);
   endtask

   // class v maps to channel v for v < 4; send until the channel's credit is gone
   task automatic exhaust(input int v);
      int n;
      n = cred_model[v];
      for (int i = 0; i < n; i++) begin
         dseq++;
         push(v, dseq);
      end
      idle(n + 5);
   endtask

   task automatic test_reset;
      int d;
      @(negedge clk);
      #1;
      chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
      d = 16'h0505;
      push(5, d);
      idle(1); #1;
      chk(out_valid == 1'b0, "R7", "out_valid one cycle after accept", int'(out_valid), 0);
      idle(1); #1;
      chk(out_valid == 1'b1, "R7", "out_valid two cycles after accept", int'(out_valid), 1);
      idle(1); #1;
      chk(out_valid == 1'b0, "R7", "single output cycle", int'(out_valid), 0);
      idle(2);
      chk(log_n == 1, "R1", "sends after reset", log_n, 1);
      entry(0, 0, 5, d, "R1");
   endtask

   task automatic test_map;
      int s;
      mapw(1, 1); mapw(2, 2); mapw(3, 3);
      mapw(5, 5);
      mapw(6, 2);
      s = log_n;
      push(5, 16'h0A05);
      push(6, 16'h0A06);
      idle(5);
      chk(log_n - s == 2, "R2", "sends after map writes", log_n - s, 2);
      entry(s, 0, 5, 16'h0A05, "R2");
      entry(s + 1, 2, 6, 16'h0A06, "R2");
   endtask

   task automatic test_full_noblock;
      int s;
      exhaust(1);
      s = log_n;
      for (int i = 0; i < QD; i++) push(1, 16'h0B00 + i);
      step(0, 1, 0, 0, 0, 0, 0, 0, 0); #1;
      chk(in_ready == 1'b0, "R4", "ready for class on full queue", int'(in_ready), 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0); #1;
      chk(in_ready == 1'b1, "R10", "ready for class on other queue", int'(in_ready), 1);
      push(1, 16'hDEAD);
      ret(2, 2);
      push(2, 16'h0B20);
      idle(5);
      chk(log_n - s == 1, "R10", "other channel sends while one is blocked", log_n - s, 1);
      entry(s, 2, 2, 16'h0B20, "R5");
      s = log_n;
      ret(1, 4);
      idle(8);
      chk(log_n - s == QD, "R4", "refused entry not sent", log_n - s, QD);
      for (int i = 0; i < QD; i++) entry(s + i, 1, 1, 16'h0B00 + i, "R11");
   endtask

   task automatic test_same_cycle;
      int s;
      exhaust(2);
      ret(2, 2);
      s = log_n;
      step(1, 2, 16'h0C00, 0, 0, 0, 0, 0, 0);
      step(1, 2, 16'h0C01, 1, 2, 1, 0, 0, 0);
      step(1, 2, 16'h0C02, 1, 2, 1, 0, 0, 0);
      step(1, 2, 16'h0C03, 0, 0, 0, 0, 0, 0);
      idle(7);
      chk(log_n - s == 4, "R6", "sends with returns during sends", log_n - s, 4);
      for (int i = 0; i < 4; i++) entry(s + i, 2, 2, 16'h0C00 + i, "R6");
      push(2, 16'h0C04);
      idle(5);
      chk(log_n - s == 4, "R5", "no send at zero credit", log_n - s, 4);
      ret(2, 1);
      idle(5);
      chk(log_n - s == 5, "R5", "send resumes after return", log_n - s, 5);
      entry(s + 4, 2, 2, 16'h0C04, "R5");
   endtask

   task automatic test_remap;
      int s;
      exhaust(1);
      ret(2, 1);
      s = log_n;
      push(1, 16'h0D0A);
      mapw(1, 2);
      push(1, 16'h0D0B);
      idle(5);
      chk(log_n - s == 1, "R3", "sends after remap", log_n - s, 1);
      entry(s, 2, 1, 16'h0D0B, "R3");
      ret(1, 1);
      idle(5);
      chk(log_n - s == 2, "R3", "queued entry released", log_n - s, 2);
      entry(s + 1, 1, 1, 16'h0D0A, "R3");
      mapw(1, 1);
   endtask

   task automatic test_iso;
      int s;
      int exp_vc [6] = '{1, 3, 3, 3, 1, 1};
      int exp_d  [6] = '{16'h0E10, 16'h0E30, 16'h0E31, 16'h0E32, 16'h0E11, 16'h0E12};
      exhaust(1);
      exhaust(3);
      s = log_n;
      for (int i = 0; i < 3; i++) push(1, 16'h0E10 + i);
      for (int i = 0; i < 3; i++) push(3, 16'h0E30 + i);
      ret(1, 3);
      ret(3, 3);
      idle(9);
      chk(log_n - s == 6, "R8", "sends in priority test", log_n - s, 6);
      for (int i = 0; i < 6; i++) entry(s + i, exp_vc[i], exp_vc[i], exp_d[i], "R8");
   endtask

   task automatic test_rr;
      int s;
      exhaust(0);
      exhaust(1);
      exhaust(2);
      s = log_n;
      for (int v = 0; v < 3; v++) begin
         push(v, 16'h0F00 + 16 * v);
         push(v, 16'h0F01 + 16 * v);
      end
      ret(0, 2);
      ret(1, 2);
      ret(2, 2);
      idle(10);
      chk(log_n - s == 6, "R9", "sends in rotation test", log_n - s, 6);
      for (int i = 0; i < 6; i++) entry(s + i, i % 3, i % 3, 16'h0F00 + 16 * (i % 3) + i / 3, "R9");
   endtask

   initial begin
      for (int v = 0; v < NVC; v++) cred_model[v] = IC;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      test_map();
      test_full_noblock();
      test_same_cycle();
      test_remap();
      test_iso();
      test_rr();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(20 * 50000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule